// File: doc/BRIEF.md
# Interrupt Vector and Status Readout Unit

This block sits behind the interrupt logic of a two-channel serial controller. It takes the raw interrupt source flags of both channels and the interrupt mask register, and it produces the interrupt request line. It also produces the status word that the host reads. When the host runs an interrupt-acknowledge cycle, the block presents an 8-bit vector. The vector is built from a base vector register in one of four ways, chosen by a 2-bit field of the global configuration register.

The vector is built from the highest-priority source that is both pending and enabled. Channel A comes before channel B. Inside a channel, a receiver error comes first, then receiver ready, then the transmitter, then any other source. A small state machine captures the vector when the acknowledge strobe is first seen. It holds that vector until the strobe drops, so changes to the sources during the cycle cannot disturb the value on the bus.

State machine: `ST_IDLE` (no acknowledge in progress; the vector output is all ones) and `ST_HOLD` (the captured vector is presented). Transitions: CAPTURE (`ST_IDLE` to `ST_HOLD` when `iack` is high at a clock edge; the vector is registered at that edge), KEEP (`ST_HOLD` to `ST_HOLD` while `iack` stays high), and RELEASE (`ST_HOLD` to `ST_IDLE` when `iack` is low at a clock edge).

Top module: `irq_vector_unit`

## Requirements
- R1: With the vector-control field `cfg_lo[2:1]` = 00, the vector presented during an acknowledge is 0xFF.
- R2: With the field = 01, the presented vector equals the base vector register as it was at capture.
- R3: With the field = 10, vector bits 7:1 are the base bits 7:1 and bit 0 is the channel code of the winning source (channel A = 0, channel B = 1).
- R4: With the field = 11, vector bits 7:3 are the base bits 7:3, bits 2:1 are the type code, and bit 0 is the channel code.
- R5: The type codes are: 11 for a receiver error, 10 for receiver ready without error, 01 for the transmitter, and 00 for other sources. Within a channel, the priority is receiver error, then receiver ready, then transmitter, then other. Flag and mask layout: channel A occupies bits 3:0 and channel B occupies bits 7:4. Within each nibble, bit 0 is receiver ready, bit 1 is receiver error, bit 2 is transmitter, and bit 3 is other.
- R6: Only sources that are both pending and enabled in the mask compete. Channel A wins over channel B. With no such source, the channel code is 0 and the type code is 00.
- R7: With `cfg_lo[0]` = 1, `stat_rd` equals the raw flags ANDed with the mask.
- R8: With `cfg_lo[0]` = 0, `stat_rd` equals the raw flags, whatever the mask.
- R9: `irq` is high exactly when some source is pending and enabled, in either status read mode.
- R10: The vector is registered at the clock edge where `iack` is first seen high in `ST_IDLE`. It is presented from the next cycle and stays unchanged, even if the inputs change, until the edge that sees `iack` low. After that edge, `vec_out` is 0xFF.
- R11: During and after reset, the state is `ST_IDLE` and `vec_out` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_flags | input | 8 | Raw interrupt source flags, two nibbles |
| src_mask | input | 8 | Interrupt enable mask, same layout |
| base_vec | input | 8 | Base vector register |
| cfg_lo | input | 3 | Global configuration bits 2:0 (vector mode, status gating) |
| iack | input | 1 | Interrupt-acknowledge strobe |
| vec_out | output | 8 | Vector for the data bus |
| irq | output | 1 | Interrupt request |
| stat_rd | output | 8 | Status word for host reads |

## Verification
The assertions assume that `src_flags`, `src_mask`, `base_vec` and `cfg_lo` are steady when the acknowledge strobe is first sampled. They also assume that `iack` changes only between clock edges. The bench meets both assumptions by changing every input on the falling clock edge, away from the capturing rising edge. Only in the hold test does it change the sources after capture, and there it deliberately tries to disturb the held vector.

// File: rtl/ivu_pkg.sv
package ivu_pkg;

    localparam int SRC_PER_CH = 4;
    localparam int SRC_RX_RDY = 0;
    localparam int SRC_RX_ERR = 1;
    localparam int SRC_TX     = 2;
    localparam int SRC_OTHER  = 3;

    localparam int CFG_GATE_BIT = 0;
    localparam int CFG_MODE_LO  = 1;

    typedef enum logic [1:0] {
        IT_OTHER = 2'b00,
        IT_TX    = 2'b01,
        IT_RX    = 2'b10,
        IT_RXERR = 2'b11
    } itype_e;

    typedef enum logic [1:0] {
        VM_NONE = 2'b00,
        VM_BASE = 2'b01,
        VM_CHAN = 2'b10,
        VM_FULL = 2'b11
    } vmode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } ack_state_e;

    function automatic itype_e type_of(input logic [SRC_PER_CH-1:0] p);
        if (p[SRC_RX_ERR])      return IT_RXERR;
        else if (p[SRC_RX_RDY]) return IT_RX;
        else if (p[SRC_TX])     return IT_TX;
        else if (p[SRC_OTHER])  return IT_OTHER;
        else                    return IT_OTHER;
    endfunction

endpackage

// File: rtl/ivu_src_arbiter.sv
module ivu_src_arbiter
    import ivu_pkg::*;
#(
    parameter int NCH  = 2,
    parameter int CH_W = 1,
    localparam int NSRC = NCH * SRC_PER_CH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] flags,
    input  logic [NSRC-1:0] mask,
    output logic            pend_any,
    output logic [CH_W-1:0] chan,
    output itype_e          itype
);

    logic [SRC_PER_CH-1:0] pend  [NCH];
    logic [NCH-1:0]        hit;
    itype_e                ptype [NCH];

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            assign pend[g]  = flags[g*SRC_PER_CH +: SRC_PER_CH] & mask[g*SRC_PER_CH +: SRC_PER_CH];
            assign hit[g]   = |pend[g];
            assign ptype[g] = type_of(pend[g]);
        end
    endgenerate

    logic [CH_W-1:0] sel;
    logic            found;

    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            if (hit[c] && !found) begin
                sel   = CH_W'(c);
                found = 1'b1;
            end
        end
    end

    assign pend_any = found;
    assign chan     = sel;
    assign itype    = found ? ptype[sel] : IT_OTHER;

    AST_ARB_A_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        hit[0] |-> chan == '0);                                     // R6
    AST_ARB_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_any |-> (chan == '0 && itype == IT_OTHER));           // R6
    AST_ARB_ERR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        pend[0][SRC_RX_ERR] |-> itype == IT_RXERR);                 // R5

endmodule

// File: rtl/ivu_vec_compose.sv
module ivu_vec_compose
    import ivu_pkg::*;
#(
    parameter int VW   = 8,
    parameter int CH_W = 1
) (
    input  vmode_e          mode,
    input  logic [VW-1:0]   base,
    input  logic [CH_W-1:0] chan,
    input  itype_e          itype,
    output logic [VW-1:0]   vec
);

    always_comb begin
        unique case (mode)
            VM_NONE: vec = '1;
            VM_BASE: vec = base;
            VM_CHAN: vec = {base[VW-1:CH_W], chan};
            VM_FULL: vec = {base[VW-1:CH_W+2], itype, chan};
        endcase
    end

endmodule

// File: rtl/ivu_status_gate.sv
module ivu_status_gate #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    input  logic [W-1:0] mask,
    input  logic         gate,
    output logic [W-1:0] stat
);

    assign stat = gate ? (raw & mask) : raw;

    AST_STAT_NO_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> (stat & ~mask) == '0);                             // R7

endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
    import ivu_pkg::*;
#(
    parameter int NCH = 2,
    parameter int VW  = 8,
    localparam int NSRC = NCH * SRC_PER_CH,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_flags,
    input  logic [NSRC-1:0] src_mask,
    input  logic [VW-1:0]   base_vec,
    input  logic [2:0]      cfg_lo,
    input  logic            iack,
    output logic [VW-1:0]   vec_out,
    output logic            irq,
    output logic [NSRC-1:0] stat_rd
);

    vmode_e          mode;
    logic            gate;
    logic            pend_any;
    logic [CH_W-1:0] chan;
    itype_e          itype;
    logic [VW-1:0]   vec_live;
    logic [VW-1:0]   vec_q;
    ack_state_e      st_q, st_d;

    assign mode = vmode_e'(cfg_lo[CFG_MODE_LO +: 2]);
    assign gate = cfg_lo[CFG_GATE_BIT];

    ivu_src_arbiter #(.NCH(NCH), .CH_W(CH_W)) i_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .flags    (src_flags),
        .mask     (src_mask),
        .pend_any (pend_any),
        .chan     (chan),
        .itype    (itype)
    );

    ivu_vec_compose #(.VW(VW), .CH_W(CH_W)) i_cmp (
        .mode  (mode),
        .base  (base_vec),
        .chan  (chan),
        .itype (itype),
        .vec   (vec_live)
    );

    ivu_status_gate #(.W(NSRC)) i_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (src_flags),
        .mask  (src_mask),
        .gate  (gate),
        .stat  (stat_rd)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (iack)  st_d = ST_HOLD;
            ST_HOLD: if (!iack) st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            vec_q <= '1;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && iack) vec_q <= vec_live;
        end
    end

    always_comb begin
        irq     = pend_any;
        vec_out = (st_q == ST_HOLD) ? vec_q : '1;
    end

    AST_MODE_NONE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && iack && mode == VM_NONE) |=> vec_out == '1);                 // R1
    AST_MODE_BASE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && iack && mode == VM_BASE) |=> vec_out == $past(base_vec));    // R2
    AST_MODE_CHAN_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && iack && mode == VM_CHAN)
            |=> vec_out[VW-1:CH_W] == $past(base_vec[VW-1:CH_W]));                      // R3
    AST_MODE_FULL_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && iack && mode == VM_FULL)
            |=> vec_out[VW-1:CH_W+2] == $past(base_vec[VW-1:CH_W+2]));                  // R4
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && iack) |=> $stable(vec_out));                                 // R10
    AST_RELEASE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && !iack) |=> vec_out == '1);                                   // R10
    AST_IRQ_SEEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && irq) |-> stat_rd != '0);                                                // R9
    AST_IRQ_LOW_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (stat_rd & src_mask) == '0);                                            // R9

endmodule

// File: tb/test_irq_vector_unit.sv
module test_irq_vector_unit;

    localparam int CLK_PERIOD = 10;
    localparam int N_TAB = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_flags = '0;
    logic [7:0] src_mask = '0;
    logic [7:0] base_vec = '0;
    logic [2:0] cfg_lo = '0;
    logic       iack = 1'b0;
    logic [7:0] vec_out;
    logic       irq;
    logic [7:0] stat_rd;

    int  total = 0;
    int  bad = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_unit i_irq_vector_unit (
        .clk(clk), .rst_n(rst_n), .src_flags(src_flags), .src_mask(src_mask),
        .base_vec(base_vec), .cfg_lo(cfg_lo), .iack(iack),
        .vec_out(vec_out), .irq(irq), .stat_rd(stat_rd)
    );

    // {cfg, base, flags, mask, expected vec, expected stat, expected irq}
    localparam logic [55:0] TAB [N_TAB] = '{
        {8'h00, 8'h00, 8'h01, 8'hFF, 8'hFF, 8'h01, 8'h01},  // R1
        {8'h02, 8'hA5, 8'h10, 8'h10, 8'hA5, 8'h10, 8'h01},  // R2
        {8'h04, 8'hA4, 8'h10, 8'hFF, 8'hA5, 8'h10, 8'h01},  // R3 channel B
        {8'h04, 8'hA5, 8'h11, 8'hFF, 8'hA4, 8'h11, 8'h01},  // R3 R6 A beats B
        {8'h06, 8'hFF, 8'h03, 8'hFF, 8'hFE, 8'h03, 8'h01},  // R4 R5 error first
        {8'h06, 8'hFF, 8'h05, 8'hFF, 8'hFC, 8'h05, 8'h01},  // R5 rx before tx
        {8'h06, 8'h00, 8'h0C, 8'hFF, 8'h02, 8'h0C, 8'h01},  // R5 tx before other
        {8'h06, 8'h00, 8'h80, 8'hFF, 8'h01, 8'h80, 8'h01},  // R5 other on B
        {8'h07, 8'h00, 8'h12, 8'hF0, 8'h05, 8'h10, 8'h01},  // R6 R7 A masked out
        {8'h07, 8'h48, 8'h0F, 8'h00, 8'h48, 8'h00, 8'h00},  // R6 R7 none enabled
        {8'h06, 8'h48, 8'h0F, 8'h00, 8'h48, 8'h0F, 8'h00},  // R8 R9 raw, no irq
        {8'h01, 8'h00, 8'h33, 8'h0F, 8'hFF, 8'h03, 8'h01},  // R1 R7
        {8'h03, 8'h3C, 8'h44, 8'h40, 8'h3C, 8'h40, 8'h01},  // R2 R7
        {8'h06, 8'h10, 8'h06, 8'h04, 8'h12, 8'h06, 8'h01},  // R5 R8 masked error
        {8'h05, 8'h00, 8'h20, 8'h20, 8'h01, 8'h20, 8'h01}   // R3 R7
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic ack_and_check(input string req, input logic [7:0] exp);
        iack = 1'b1;
        @(negedge clk);
        check(req, vec_out, exp);
        iack = 1'b0;
        @(negedge clk);
        check("R10 release", vec_out, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset vec", vec_out, 8'hFF);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after reset", vec_out, 8'hFF);

        for (int i = 0; i < N_TAB; i++) begin
            logic [55:0] e;
            e = TAB[i];
            @(negedge clk);
            cfg_lo    = e[50:48];
            base_vec  = e[47:40];
            src_flags = e[39:32];
            src_mask  = e[31:24];
            #1;
            check("R7 R8 status", stat_rd, e[15:8]);
            check("R9 irq", {7'b0, irq}, e[7:0]);
            ack_and_check("R1 R2 R3 R4 R5 R6 vector", e[23:16]);
        end

        // R10: held vector survives source and register changes
        @(negedge clk);
        cfg_lo = 3'b110; base_vec = 8'hF0; src_flags = 8'h02; src_mask = 8'hFF;
        iack = 1'b1;
        @(negedge clk);
        check("R10 captured", vec_out, 8'hF6);
        src_flags = 8'h80; base_vec = 8'h00; cfg_lo = 3'b010;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R10 held", vec_out, 8'hF6);
        end
        iack = 1'b0;
        @(negedge clk);
        check("R10 idle ones", vec_out, 8'hFF);
        ack_and_check("R2 new capture", 8'h00);

        // R11: reset during hold
        iack = 1'b1;
        @(negedge clk);
        check("R2 before reset", vec_out, 8'h00);
        rst_n = 1'b0;
        #1;
        check("R11 reset in hold", vec_out, 8'hFF);
        iack = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 idle after reset", vec_out, 8'hFF);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule